// File: doc/BRIEF.md
# Event-timer channel interrupt router

This block sits beside the comparators of a multi-channel event timer and turns each channel's fire strobe into an interrupt. For every channel it decides whether an interrupt is raised at all and which delivery path carries it. The three paths are a one-cycle edge pulse on a numbered interrupt-controller pin, a level assertion on such a pin that stays held until cleared, or a message request carrying a 32-bit address and 32-bit data word.

Each channel keeps a level status bit. That bit is dropped, together with a deassert strobe to the pin it was holding, when software clears it or when a configuration write would leave the level stuck. Configuration writes are screened against a per-channel allowed-pin mask. The mask is fixed at elaboration from the number of controller pins.

Software reaches the block through a shared write port and a read port. The write port, with a channel select, loads a channel's configuration word or its 64-bit message word. The read port returns a selected channel's configuration word. Outputs are grouped per channel, so several channels may signal in the same cycle without arbitration.

Top module: `tirq_router`

## Requirements
- R1: After reset every status bit is 0. Every configuration readback has bits 1, 2 and 9 to 14 at 0. Bits 63:32 hold the allowed-pin mask. Bit 15 shows the channel's message capability.
- R2: A fire strobe on a channel whose interrupt-enable bit (configuration bit 2) is 0 produces no pulse, no assert and no message request.
- R3: A fire strobe on a channel whose status bit is already 1 produces no pulse, no assert and no message request.
- R4: A channel with message capability (bit 15) and message enable (bit 14) both set answers an enabled fire with a message request. The address is bits 63:32 of its message word and the data is bits 31:0. No pin strobe is produced.
- R5: A channel with route 0 (configuration bits 13:9), or in message mode, drives no pin strobe when it fires.
- R6: An enabled fire on an edge-type channel (bit 1 = 0) with a nonzero route gives a one-cycle pulse on that pin. The status bit stays 0.
- R7: An enabled fire on a level-type channel (bit 1 = 1) with a nonzero route gives an assert strobe on that pin. The status bit reads 1 from the next cycle.
- R8: A configuration write whose route names a pin whose bit in the allowed-pin mask is 0 stores route 0. The reset mask is 0xFF000000 for 32 or more pins, the four highest pins for 20 to 31 pins, and empty below 20.
- R9: A set status bit clears, with a deassert strobe on the old pin, when a configuration write disables the interrupt, selects message mode, selects edge type or changes the effective pin.
- R10: A clear request on a channel whose status bit is set gives a deassert strobe on its current pin, and the status bit reads 0 from the next cycle.
- R11: A fire in the same cycle as a configuration write to that channel is judged against the newly written configuration. A message in the same cycle as a message-word write carries the previous message word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fire | input | NCH | Per-channel comparator fire strobe |
| clr_mask | input | NCH | Per-channel status clear request |
| wr_sel | input | SEL_W | Channel targeted by a write |
| cfg_we | input | 1 | Write wr_data into the selected channel's configuration |
| msg_we | input | 1 | Write wr_data into the selected channel's message word |
| wr_data | input | 64 | Write data |
| rd_sel | input | SEL_W | Channel whose configuration is read back |
| rd_cfg | output | 64 | Configuration word of channel rd_sel |
| status | output | NCH | Per-channel level status bits |
| irq_pin | output | NCH*5 | Per-channel pin number for the strobes |
| irq_assert | output | NCH | Per-channel level assert strobe |
| irq_deassert | output | NCH | Per-channel level deassert strobe |
| irq_pulse | output | NCH | Per-channel edge pulse |
| msg_req | output | NCH | Per-channel message request |
| msg_addr | output | NCH*32 | Per-channel message address |
| msg_data | output | NCH*32 | Per-channel message data |

## Verification
The bench builds the block with four channels and 24 controller pins, which makes the allowed set pins 20 to 23. Routes to pins 0 to 19 and 24 to 31 therefore exercise the forced-to-zero path. Message capability is set on channels 0 to 2 and left off on channel 3. This lets the bench check a channel whose message-enable bit is set but that must still deliver through its pin. With four channels, fires, clears and writes on different channels overlap in the same cycle, and the per-channel lanes are checked against one another.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
   localparam int unsigned ROUTE_W   = 5;
   localparam int unsigned B_LEVEL   = 1;
   localparam int unsigned B_ENABLE  = 2;
   localparam int unsigned ROUTE_LO  = 9;
   localparam int unsigned B_MSG_EN  = 14;
   localparam int unsigned B_MSG_CAP = 15;

   function automatic logic [31:0] allowed_pins(input int unsigned npins);
      if (npins >= 32)      return 32'hFF00_0000;
      else if (npins >= 20) return 32'hF << (npins - 4);
      else                  return 32'h0;
   endfunction
endpackage

// File: rtl/tirq_rdmux.sv
module tirq_rdmux #(
   parameter int NCH   = 4,
   parameter int SEL_W = 2
) (
   input  logic [NCH*64-1:0] words,
   input  logic [SEL_W-1:0]  sel,
   output logic [63:0]       word
);
   always_comb begin
      word = '0;
      for (int i = 0; i < NCH; i++)
         if (sel == SEL_W'(i)) word = words[i*64 +: 64];
   end
endmodule

// File: rtl/tirq_chan.sv
module tirq_chan
   import tirq_pkg::*;
#(
   parameter bit          MSG_CAPABLE = 1'b1,
   parameter logic [31:0] ALLOWED     = 32'h0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire,
   input  logic               clr,
   input  logic               cfg_we,
   input  logic               msg_we,
   input  logic [63:0]        wdata,
   output logic [63:0]        cfg_word,
   output logic               status,
   output logic [ROUTE_W-1:0] pin,
   output logic               pin_assert,
   output logic               pin_deassert,
   output logic               pin_pulse,
   output logic               msg_req,
   output logic [31:0]        msg_addr,
   output logic [31:0]        msg_data
);
   logic               enb_q, lvl_q, msgen_q, stat_q;
   logic [ROUTE_W-1:0] route_q;
   logic [63:0]        msg_q;

   logic [ROUTE_W-1:0] wr_route, new_route, eff_route, old_pin, eff_pin;
   logic               eff_enb, eff_lvl, eff_msgen, old_msg, eff_msg;
   logic               drop, clr_hit, act;

   // route screening against the allowed-pin mask
   assign wr_route  = wdata[ROUTE_LO +: ROUTE_W];
   assign new_route = (wr_route == '0 || ALLOWED[wr_route]) ? wr_route : '0;

   // configuration in force this cycle (a same-cycle write wins)
   assign eff_enb   = cfg_we ? wdata[B_ENABLE] : enb_q;
   assign eff_lvl   = cfg_we ? wdata[B_LEVEL]  : lvl_q;
   assign eff_msgen = cfg_we ? wdata[B_MSG_EN] : msgen_q;
   assign eff_route = cfg_we ? new_route       : route_q;

   assign old_msg = MSG_CAPABLE && msgen_q;
   assign eff_msg = MSG_CAPABLE && eff_msgen;
   assign old_pin = old_msg ? '0 : route_q;
   assign eff_pin = eff_msg ? '0 : eff_route;

   // stale level removal
   assign drop    = stat_q && cfg_we &&
                    (!eff_enb || eff_msg || !eff_lvl || eff_pin != old_pin);
   assign clr_hit = stat_q && clr;

   // delivery
   assign act          = fire && eff_enb && !stat_q;
   assign msg_req      = act && eff_msg;
   assign pin_pulse    = act && !eff_msg && eff_pin != '0 && !eff_lvl;
   assign pin_assert   = act && !eff_msg && eff_pin != '0 && eff_lvl;
   assign pin_deassert = drop || clr_hit;
   assign pin          = pin_deassert ? old_pin : eff_pin;
   assign msg_addr     = msg_q[63:32];
   assign msg_data     = msg_q[31:0];
   assign status       = stat_q;

   assign cfg_word = {ALLOWED, 16'h0, MSG_CAPABLE, msgen_q, route_q, 6'h0,
                      enb_q, lvl_q, 1'b0};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enb_q   <= 1'b0;
         lvl_q   <= 1'b0;
         msgen_q <= 1'b0;
         route_q <= '0;
         stat_q  <= 1'b0;
         msg_q   <= '0;
      end else begin
         if (cfg_we) begin
            enb_q   <= wdata[B_ENABLE];
            lvl_q   <= wdata[B_LEVEL];
            msgen_q <= wdata[B_MSG_EN];
            route_q <= new_route;
         end
         if (msg_we) msg_q <= wdata;
         if (pin_deassert)    stat_q <= 1'b0;
         else if (pin_assert) stat_q <= 1'b1;
      end
   end

   a_r7_level_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
      pin_assert |=> status);
   a_r3_busy_ignores_fire: assert property (@(posedge clk) disable iff (!rst_n)
      (status && fire) |-> !(pin_assert || pin_pulse || msg_req));
   a_r10_deassert_clears: assert property (@(posedge clk) disable iff (!rst_n)
      pin_deassert |=> !status);
   a_r5_strobe_has_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_assert || pin_pulse || pin_deassert) |-> pin != '0);
   a_r6_edge_no_status: assert property (@(posedge clk) disable iff (!rst_n)
      pin_pulse |=> !status);
   a_r2_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !cfg_we && !cfg_word[B_ENABLE]) |-> !(pin_assert || pin_pulse || msg_req));
   a_r7_status_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status) |-> $past(pin_assert));
endmodule

// File: rtl/tirq_router.sv
module tirq_router
   import tirq_pkg::*;
#(
   parameter int             NCH     = 4,
   parameter int             NPINS   = 24,
   parameter logic [NCH-1:0] MSG_CAP = '1,
   localparam int            SEL_W   = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NCH-1:0]       fire,
   input  logic [NCH-1:0]       clr_mask,
   input  logic [SEL_W-1:0]     wr_sel,
   input  logic                 cfg_we,
   input  logic                 msg_we,
   input  logic [63:0]          wr_data,
   input  logic [SEL_W-1:0]     rd_sel,
   output logic [63:0]          rd_cfg,
   output logic [NCH-1:0]       status,
   output logic [NCH*ROUTE_W-1:0] irq_pin,
   output logic [NCH-1:0]       irq_assert,
   output logic [NCH-1:0]       irq_deassert,
   output logic [NCH-1:0]       irq_pulse,
   output logic [NCH-1:0]       msg_req,
   output logic [NCH*32-1:0]    msg_addr,
   output logic [NCH*32-1:0]    msg_data
);
   localparam logic [31:0] ALLOWED = allowed_pins(NPINS);

   if (NCH < 1 || NCH > 32) begin : g_bad_nch
      $fatal(1, "tirq_router: NCH must be 1..32");
   end
   if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
      $fatal(1, "tirq_router: NPINS must be 1..32");
   end

   logic [NCH*64-1:0] words;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic sel_hit;
      assign sel_hit = (wr_sel == SEL_W'(i));

      tirq_chan #(
         .MSG_CAPABLE (MSG_CAP[i]),
         .ALLOWED     (ALLOWED)
      ) i_chan (
         .clk          (clk),
         .rst_n        (rst_n),
         .fire         (fire[i]),
         .clr          (clr_mask[i]),
         .cfg_we       (cfg_we && sel_hit),
         .msg_we       (msg_we && sel_hit),
         .wdata        (wr_data),
         .cfg_word     (words[i*64 +: 64]),
         .status       (status[i]),
         .pin          (irq_pin[i*ROUTE_W +: ROUTE_W]),
         .pin_assert   (irq_assert[i]),
         .pin_deassert (irq_deassert[i]),
         .pin_pulse    (irq_pulse[i]),
         .msg_req      (msg_req[i]),
         .msg_addr     (msg_addr[i*32 +: 32]),
         .msg_data     (msg_data[i*32 +: 32])
      );
   end

   tirq_rdmux #(.NCH(NCH), .SEL_W(SEL_W)) i_rdmux (
      .words (words),
      .sel   (rd_sel),
      .word  (rd_cfg)
   );
endmodule

// File: tb/test_tirq_router.sv
module test_tirq_router;
   localparam int          NCH   = 4;
   localparam logic [3:0]  CAP   = 4'b0111;
   localparam logic [31:0] ALLOW = 32'h00F0_0000;

   logic clk = 1'b0;
   logic rst_n;
   logic [3:0]  fire, clr_mask;
   logic [1:0]  wr_sel, rd_sel;
   logic        cfg_we, msg_we;
   logic [63:0] wr_data;
   logic [63:0] rd_cfg;
   logic [3:0]  status, irq_assert, irq_deassert, irq_pulse, msg_req;
   logic [19:0] irq_pin;
   logic [127:0] msg_addr, msg_data;

   always #4 clk = ~clk;

   tirq_router #(.NCH(NCH), .NPINS(24), .MSG_CAP(CAP)) i_tirq_router (
      .clk(clk), .rst_n(rst_n), .fire(fire), .clr_mask(clr_mask),
      .wr_sel(wr_sel), .cfg_we(cfg_we), .msg_we(msg_we), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_cfg(rd_cfg), .status(status), .irq_pin(irq_pin),
      .irq_assert(irq_assert), .irq_deassert(irq_deassert),
      .irq_pulse(irq_pulse), .msg_req(msg_req),
      .msg_addr(msg_addr), .msg_data(msg_data));

   int total = 0, bad = 0;
   bit done = 1'b0;

   logic        m_enb[4], m_lvl[4], m_msgen[4], m_stat[4];
   logic [4:0]  m_route[4];
   logic [63:0] m_msg[4];

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [63:0] model_word(input int c);
      return {ALLOW, 16'h0, CAP[c], m_msgen[c], m_route[c], 6'h0,
              m_enb[c], m_lvl[c], 1'b0};
   endfunction

   function automatic logic [4:0] screen(input logic [4:0] r);
      return (r == 5'd0 || ALLOW[r]) ? r : 5'd0;
   endfunction

   task automatic step(input logic [3:0] f, input logic [3:0] cl,
                       input logic [1:0] ws, input logic cw_i, input logic mw_i,
                       input logic [63:0] wd, input logic [1:0] rs);
      @(negedge clk);
      fire = f; clr_mask = cl; wr_sel = ws; cfg_we = cw_i; msg_we = mw_i;
      wr_data = wd; rd_sel = rs;
      #1;
      chk("R8", "cfg readback", rd_cfg, model_word(int'(rs)));
      for (int c = 0; c < NCH; c++) begin
         logic cw, mw, e_enb, e_lvl, e_msgen, om, em, drop, clh, act;
         logic x_pulse, x_assert, x_deas, x_msg;
         logic [4:0] e_route, op, ep, x_pin;
         string tf, td;
         cw = cw_i && (ws == 2'(c));
         mw = mw_i && (ws == 2'(c));
         e_enb   = cw ? wd[2]  : m_enb[c];
         e_lvl   = cw ? wd[1]  : m_lvl[c];
         e_msgen = cw ? wd[14] : m_msgen[c];
         e_route = cw ? screen(wd[13:9]) : m_route[c];
         om = CAP[c] && m_msgen[c];
         em = CAP[c] && e_msgen;
         op = om ? 5'd0 : m_route[c];
         ep = em ? 5'd0 : e_route;
         drop = m_stat[c] && cw && (!e_enb || em || !e_lvl || ep != op);
         clh  = m_stat[c] && cl[c];
         act  = f[c] && e_enb && !m_stat[c];
         x_msg    = act && em;
         x_pulse  = act && !em && ep != 0 && !e_lvl;
         x_assert = act && !em && ep != 0 && e_lvl;
         x_deas   = drop || clh;
         x_pin    = x_deas ? op : ep;
         if (f[c] && !e_enb)               tf = "R2";
         else if (f[c] && m_stat[c])       tf = "R3";
         else if (f[c] && cw)              tf = "R11";
         else if (f[c] && em)              tf = "R4";
         else if (f[c] && ep == 0)         tf = "R5";
         else if (f[c] && e_lvl)           tf = "R7";
         else                              tf = "R6";
         td = drop ? "R9" : "R10";
         chk("R7", $sformatf("status ch%0d", c), 64'(status[c]), 64'(m_stat[c]));
         chk(tf, $sformatf("pulse ch%0d", c),  64'(irq_pulse[c]),  64'(x_pulse));
         chk(tf, $sformatf("assert ch%0d", c), 64'(irq_assert[c]), 64'(x_assert));
         chk(tf, $sformatf("msg ch%0d", c),    64'(msg_req[c]),    64'(x_msg));
         chk(td, $sformatf("deassert ch%0d", c), 64'(irq_deassert[c]), 64'(x_deas));
         if (x_pulse || x_assert || x_deas)
            chk(x_deas ? td : tf, $sformatf("pin ch%0d", c),
                64'(irq_pin[c*5 +: 5]), 64'(x_pin));
         if (x_msg) begin
            chk(mw ? "R11" : "R4", $sformatf("addr ch%0d", c),
                64'(msg_addr[c*32 +: 32]), 64'(m_msg[c][63:32]));
            chk(mw ? "R11" : "R4", $sformatf("data ch%0d", c),
                64'(msg_data[c*32 +: 32]), 64'(m_msg[c][31:0]));
         end
         // model update for the coming edge
         if (cw) begin
            m_enb[c] = wd[2]; m_lvl[c] = wd[1]; m_msgen[c] = wd[14];
            m_route[c] = screen(wd[13:9]);
         end
         if (mw) m_msg[c] = wd;
         if (x_deas)        m_stat[c] = 1'b0;
         else if (x_assert) m_stat[c] = 1'b1;
      end
   endtask

   function automatic logic [63:0] cfgw(input logic lvl, input logic enb,
                                        input logic [4:0] r, input logic me);
      logic [63:0] w;
      w = '0; w[1] = lvl; w[2] = enb; w[13:9] = r; w[14] = me;
      return w;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog (R1..all) actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; fire = '0; clr_mask = '0; wr_sel = '0; rd_sel = '0;
      cfg_we = 1'b0; msg_we = 1'b0; wr_data = '0;
      for (int c = 0; c < NCH; c++) begin
         m_enb[c] = 0; m_lvl[c] = 0; m_msgen[c] = 0; m_stat[c] = 0;
         m_route[c] = 0; m_msg[c] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1: reset state
      for (int c = 0; c < NCH; c++) begin
         rd_sel = 2'(c); #1;
         chk("R1", "reset cfg", rd_cfg, {ALLOW, 16'h0, CAP[c], 15'h0});
      end
      chk("R1", "reset status", 64'(status), 64'h0);

      // directed: level on ch0 pin 21, ignore repeat, clear
      step(4'h0, 4'h0, 2'd0, 1, 0, cfgw(1, 1, 5'd21, 0), 2'd0);
      step(4'h1, 4'h0, 2'd0, 0, 0, '0, 2'd0);          // R7 assert
      step(4'h1, 4'h0, 2'd0, 0, 0, '0, 2'd0);          // R3 ignored
      step(4'h0, 4'h1, 2'd0, 0, 0, '0, 2'd0);          // R10 clear
      // R8: disallowed route 5 and 24 forced to 0
      step(4'h0, 4'h0, 2'd0, 1, 0, cfgw(1, 1, 5'd5, 0), 2'd0);
      step(4'h1, 4'h0, 2'd0, 0, 0, '0, 2'd0);          // R5 route 0
      step(4'h0, 4'h0, 2'd0, 1, 0, cfgw(0, 1, 5'd24, 0), 2'd0);
      // R6: edge on ch1 pin 23
      step(4'h0, 4'h0, 2'd1, 1, 0, cfgw(0, 1, 5'd23, 0), 2'd1);
      step(4'h2, 4'h0, 2'd0, 0, 0, '0, 2'd1);
      // R2: disabled
      step(4'h0, 4'h0, 2'd1, 1, 0, cfgw(0, 0, 5'd23, 0), 2'd1);
      step(4'h2, 4'h0, 2'd0, 0, 0, '0, 2'd1);
      // R4 / R11: message on ch2, same-cycle message write keeps old word
      step(4'h0, 4'h0, 2'd2, 0, 1, 64'hDEAD_BEEF_0123_4567, 2'd2);
      step(4'h0, 4'h0, 2'd2, 1, 0, cfgw(1, 1, 5'd20, 1), 2'd2);
      step(4'h4, 4'h0, 2'd2, 0, 1, 64'h1111_2222_3333_4444, 2'd2);
      step(4'h4, 4'h0, 2'd0, 0, 0, '0, 2'd2);
      // ch3 not message capable: pin path despite message enable
      step(4'h0, 4'h0, 2'd3, 1, 0, cfgw(1, 1, 5'd22, 1), 2'd3);
      step(4'h8, 4'h0, 2'd0, 0, 0, '0, 2'd3);
      // R9: route change drops ch3 level
      step(4'h0, 4'h0, 2'd3, 1, 0, cfgw(1, 1, 5'd20, 1), 2'd3);
      // R9: edge switch drops ch0 level
      step(4'h0, 4'h0, 2'd0, 1, 0, cfgw(1, 1, 5'd21, 0), 2'd0);
      step(4'h1, 4'h0, 2'd0, 0, 0, '0, 2'd0);
      step(4'h0, 4'h0, 2'd0, 1, 0, cfgw(0, 1, 5'd21, 0), 2'd0);
      // R11: fire with same-cycle config write
      step(4'h1, 4'h0, 2'd0, 1, 0, cfgw(1, 1, 5'd22, 0), 2'd0);

      // constrained random
      for (int n = 0; n < 4000; n++) begin
         logic [3:0]  f, cl;
         logic [63:0] wd;
         logic        cw, mw;
         int          k;
         f  = 4'($urandom) & 4'($urandom);
         cl = 4'($urandom) & 4'($urandom) & 4'($urandom);
         cw = ($urandom % 4) == 0;
         mw = ($urandom % 8) == 0;
         wd = {$urandom, $urandom};
         k  = $urandom % 4;
         if (k == 0)      wd[13:9] = 5'd0;
         else if (k != 3) wd[13:9] = 5'(20 + ($urandom % 4));
         step(f, cl, 2'($urandom), cw, mw, wd, 2'($urandom));
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule